// File: doc/BRIEF.md
# SPI Burst Master

This block is a master-only SPI engine that runs one framed transaction per start command. Software loads a transmit FIFO with header bytes, programs a total byte count and a smaller count of bytes to be taken from the transmit FIFO, and then sets a start bit. The engine holds chip select low for the whole burst. It shifts out the FIFO bytes first and clocks 0x00 filler for the rest. Every byte received during the burst goes into a receive FIFO, including the bytes clocked while the header went out.

The serial clock comes from the reference clock through a programmable divider with two modes. It follows SPI mode 0: the clock idles low, data is sampled on the rising edge and shifted on the falling edge, and bytes go most significant bit first. A status word reports both FIFO fill levels and a sticky underflow flag. A self-clearing soft reset brings the engine, FIFOs and counters back to idle.

Register word addresses on `bus_addr`: 0 control, 1 divider, 2 total count, 3 source count, 4 transmit data (write), 5 receive data (read), 6 status.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, control reads 0, divider reads 0x1000, status reads 0, `spi_cs_n` is 1 and `spi_sck` is 0.
- R2: During a burst, `spi_cs_n` stays low for exactly (total count × 8) serial clock cycles in SPI mode 0, most significant bit first. When no burst is active, `spi_cs_n` is high and `spi_sck` is low.
- R3: The first (source count) bytes on MOSI are popped from the transmit FIFO. Every later byte is 0x00, and so is any source byte requested while the transmit FIFO is empty. Bytes beyond the source count stay in the transmit FIFO.
- R4: Each byte received during the burst is pushed into the receive FIFO (depth 64) in arrival order. Status bits [6:0] give the receive fill level, which can reach 64.
- R5: Writing control with start (bit 4), enable (bit 0) and master (bit 1) all set launches a burst when the total count is nonzero. Without enable and master the write is ignored. Control bit 4 reads 1 while the burst runs and 0 afterwards.
- R6: With divider bit 12 set, the serial clock period is 2×(N+1) reference cycles, where N is divider bits [7:0]. With bit 12 clear, the period is 2^(M+1) cycles, where M is divider bits [11:8].
- R7: Chip select falls one half period before the first rising edge of the serial clock and rises one half period after its last falling edge.
- R8: A control write with bit 2 set empties the transmit FIFO. A control write with bit 3 set empties the receive FIFO and clears the underflow flag.
- R9: A write to transmit data while the transmit FIFO holds 64 bytes is dropped. Status bits [14:8] give the transmit fill level.
- R10: A read of receive data while the receive FIFO is empty returns 0 and sets the sticky underflow flag in status bit 16.
- R11: A control write with bit 5 set aborts any burst and clears both FIFOs, both counts and the underflow flag. Control bit 5 reads 1 until this is done and then clears itself. Enable, master and the divider are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Master data in |

## Verification
The assertions take for granted that software does not change the divider while a burst runs. They also assume the receive strobe and control writes are one-cycle pulses aligned to the reference clock. The stimulus writes the divider only between bursts and waits for the start bit to read 0 before issuing the next start. The one exception is the soft-reset case, where the abort is the behaviour under test. The bench's device model changes MISO only on falling serial clock edges and on the chip-select fall, so every rising-edge sample sees a settled level.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_DIV   = 3'd1,
    A_TOTAL = 3'd2,
    A_SRC   = 3'd3,
    A_TXD   = 3'd4,
    A_RXD   = 3'd5,
    A_STAT  = 3'd6
  } reg_addr_e;

  localparam int CTL_EN   = 0;
  localparam int CTL_MST  = 1;
  localparam int CTL_TXFL = 2;
  localparam int CTL_RXFL = 3;
  localparam int CTL_GO   = 4;
  localparam int CTL_SRST = 5;

  localparam int           DIV_W     = 13;
  localparam logic [12:0]  DIV_RESET = 13'h1000;
  localparam int           SRST_LEN  = 3;

  typedef enum logic [1:0] { ENG_IDLE, ENG_SHIFT, ENG_TAIL } eng_state_e;

  // Reference cycles per half period of the serial clock.
  function automatic logic [15:0] half_period(input logic [12:0] div);
    if (div[12]) return {8'd0, div[7:0]} + 16'd1;
    else         return 16'd1 << div[11:8];
  endfunction

endpackage

// File: rtl/spi_burst_fifo.sv
module spi_burst_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty,
  output logic [LW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic             do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      level <= level + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= wdata;
  end
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic [CNT_W-1:0] total_len,
  input  logic [CNT_W-1:0] src_len,
  input  logic [15:0]      half,
  input  logic [7:0]       tx_byte,
  input  logic             tx_empty,
  output logic             tx_pop,
  output logic [7:0]       rx_byte,
  output logic             rx_push,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso,
  output logic             busy,
  output logic             byte_end,
  output logic             sck_tick
);
  eng_state_e       state;
  logic [15:0]      div_cnt;
  logic [7:0]       tx_sh, rx_sh;
  logic [2:0]       bit_cnt;
  logic [CNT_W-1:0] done_cnt, used_cnt, used_now;
  logic             last_byte, load, need_src;
  logic [7:0]       next_byte;

  assign sck_tick  = (state != ENG_IDLE) && (div_cnt >= half - 16'd1);
  assign byte_end  = (state == ENG_SHIFT) && sck_tick && sck && (bit_cnt == 3'd7);
  assign last_byte = (done_cnt + CNT_W'(1)) == total_len;
  assign load      = ((state == ENG_IDLE) && start) || (byte_end && !last_byte);
  assign used_now  = (state == ENG_IDLE) ? '0 : used_cnt;
  assign need_src  = used_now < src_len;
  assign tx_pop    = load && need_src && !tx_empty;
  assign next_byte = tx_pop ? tx_byte : 8'h00;
  assign rx_push   = byte_end;
  assign rx_byte   = rx_sh;
  assign mosi      = !cs_n && tx_sh[7];
  assign busy      = (state != ENG_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ENG_IDLE; div_cnt <= '0; sck <= 1'b0; cs_n <= 1'b1;
      tx_sh <= '0; rx_sh <= '0; bit_cnt <= '0; done_cnt <= '0; used_cnt <= '0;
    end else if (abort) begin
      state <= ENG_IDLE; div_cnt <= '0; sck <= 1'b0; cs_n <= 1'b1;
      tx_sh <= '0; rx_sh <= '0; bit_cnt <= '0; done_cnt <= '0; used_cnt <= '0;
    end else begin
      if (state != ENG_IDLE) div_cnt <= sck_tick ? 16'd0 : div_cnt + 16'd1;
      unique case (state)
        ENG_IDLE: if (start) begin
          state    <= ENG_SHIFT;
          cs_n     <= 1'b0;
          div_cnt  <= '0;
          bit_cnt  <= '0;
          done_cnt <= '0;
          tx_sh    <= next_byte;
          used_cnt <= CNT_W'(need_src);
        end
        ENG_SHIFT: if (sck_tick) begin
          if (!sck) begin
            sck   <= 1'b1;
            rx_sh <= {rx_sh[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bit_cnt == 3'd7) begin
              bit_cnt  <= '0;
              done_cnt <= done_cnt + CNT_W'(1);
              if (last_byte) state <= ENG_TAIL;
              else begin
                tx_sh    <= next_byte;
                used_cnt <= used_cnt + CNT_W'(need_src);
              end
            end else begin
              tx_sh   <= {tx_sh[6:0], 1'b0};
              bit_cnt <= bit_cnt + 3'd1;
            end
          end
        end
        ENG_TAIL: if (sck_tick) begin
          state <= ENG_IDLE;
          cs_n  <= 1'b1;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic             en_q, mst_q, underflow_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] total_q, src_q;
  logic [1:0]       srst_cnt;
  logic             srst_act, wr_ctrl, go, tx_wr, rx_rd;
  logic             tx_flush, rx_flush, tx_pop, rx_push, tx_full, tx_empty, rx_full, rx_empty;
  logic             eng_busy, byte_end, sck_tick;
  logic [7:0]       tx_head, rx_head, rx_byte;
  logic [LW-1:0]    tx_level, rx_level;
  logic [31:0]      stat_word;

  assign srst_act = (srst_cnt != 2'd0);
  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign tx_wr    = bus_wr && (bus_addr == A_TXD) && !srst_act;
  assign rx_rd    = bus_rd && (bus_addr == A_RXD);
  assign tx_flush = (wr_ctrl && bus_wdata[CTL_TXFL]) || srst_act;
  assign rx_flush = (wr_ctrl && bus_wdata[CTL_RXFL]) || srst_act;
  assign go = wr_ctrl && bus_wdata[CTL_GO] && bus_wdata[CTL_EN] && bus_wdata[CTL_MST]
              && !bus_wdata[CTL_SRST] && (total_q != '0) && !eng_busy && !srst_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; mst_q <= 1'b0; div_q <= DIV_RESET;
      total_q <= '0; src_q <= '0; srst_cnt <= '0; underflow_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= bus_wdata[CTL_EN];
        mst_q <= bus_wdata[CTL_MST];
      end
      if (wr_ctrl && bus_wdata[CTL_SRST]) srst_cnt <= 2'(SRST_LEN);
      else if (srst_act)                  srst_cnt <= srst_cnt - 2'd1;
      if (bus_wr && bus_addr == A_DIV) div_q <= bus_wdata[DIV_W-1:0];
      if (srst_act) begin
        total_q <= '0; src_q <= '0;
      end else if (!eng_busy && bus_wr) begin
        if (bus_addr == A_TOTAL) total_q <= CNT_W'(bus_wdata);
        if (bus_addr == A_SRC)   src_q   <= CNT_W'(bus_wdata);
      end
      if (rx_flush)                 underflow_q <= 1'b0;
      else if (rx_rd && rx_empty)   underflow_q <= 1'b1;
    end
  end

  spi_burst_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_wr), .wdata(bus_wdata[7:0]),
    .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty), .level(tx_level));

  spi_burst_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push), .wdata(rx_byte),
    .pop(rx_rd), .rdata(rx_head), .full(rx_full), .empty(rx_empty), .level(rx_level));

  spi_burst_engine #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .abort(srst_act), .start(go),
    .total_len(total_q), .src_len(src_q), .half(half_period(div_q)),
    .tx_byte(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
    .rx_byte(rx_byte), .rx_push(rx_push),
    .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso),
    .busy(eng_busy), .byte_end(byte_end), .sck_tick(sck_tick));

  always_comb begin
    stat_word = '0;
    stat_word[LW-1:0]   = rx_level;
    stat_word[8+:LW]    = tx_level;
    stat_word[16]       = underflow_q;
  end

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  bus_rdata = {26'd0, srst_act, eng_busy, 2'b00, mst_q, en_q};
      A_DIV:   bus_rdata = {19'd0, div_q};
      A_TOTAL: bus_rdata = 32'(total_q);
      A_SRC:   bus_rdata = 32'(src_q);
      A_RXD:   bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_head};
      A_STAT:  bus_rdata = stat_word;
      default: bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/spi_burst_checks.sv
module spi_burst_checks #(
  parameter int DEPTH = 64,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spi_sck,
  input logic          spi_cs_n,
  input logic          spi_mosi,
  input logic          eng_busy,
  input logic          rx_push,
  input logic          tx_pop,
  input logic          tx_wr,
  input logic          tx_full,
  input logic          tx_flush,
  input logic          rx_flush,
  input logic          underflow_q,
  input logic          srst_act,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> (spi_cs_n && !spi_sck));

  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  p_push_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !spi_sck);

  p_rx_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LW'(DEPTH));

  p_tx_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_wr && !tx_pop && !tx_flush) |=> (tx_level == $past(tx_level)));

  p_uf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow_q && !rx_flush) |=> underflow_q);

  p_srst_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    srst_act |=> (tx_level == '0 && rx_level == '0 && spi_cs_n));
endmodule

bind spi_burst_master spi_burst_checks #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
  .eng_busy(eng_busy), .rx_push(rx_push), .tx_pop(tx_pop), .tx_wr(tx_wr),
  .tx_full(tx_full), .tx_flush(tx_flush), .rx_flush(rx_flush),
  .underflow_q(underflow_q), .srst_act(srst_act),
  .tx_level(tx_level), .rx_level(rx_level));

// File: tb/spi_burst_master_bench.sv
module spi_burst_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  always #4 clk = ~clk;

  spi_burst_master u_spi_burst_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_mosi[$];
  logic [7:0] exp_rx[$];
  logic [7:0] hdr_q[$];

  function automatic logic [7:0] resp(input int k);
    return 8'(32'h3C + k * 29);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Device model on the bus pins, acting as the scoreboard monitor for MOSI.
  logic [7:0] s_in = '0, s_out = '0;
  int s_bit = 0, s_idx = 0;
  bit s_reload = 1'b0;

  always @(negedge spi_cs_n) begin
    s_idx = 0; s_bit = 0; s_reload = 1'b0;
    s_out = resp(0);
    spi_miso = s_out[7];
  end

  always @(posedge spi_sck) begin
    s_in = {s_in[6:0], spi_mosi};
    s_bit++;
    if (s_bit == 8) begin
      if (exp_mosi.size() == 0) chk("R3 unexpected MOSI byte", int'(s_in), -1);
      else chk("R3 MOSI byte", int'(s_in), int'(exp_mosi.pop_front()));
      s_bit = 0; s_idx++;
      s_out = resp(s_idx);
      s_reload = 1'b1;
    end
  end

  always @(negedge spi_sck) begin
    if (s_reload) s_reload = 1'b0;
    else s_out = {s_out[6:0], 1'b0};
    spi_miso = s_out[7];
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  // Driver: loads hdr_q, queues expectations, starts, measures the frame timing.
  task automatic run_burst(input int total, input int src, input int half, input bit drain);
    logic [31:0] v;
    int nh, lo, hi, tail;
    nh = hdr_q.size();
    foreach (hdr_q[i]) wr(3'd4, {8'd0, hdr_q[i]});
    for (int k = 0; k < total; k++) begin
      exp_mosi.push_back((k < src && k < nh) ? hdr_q[k] : 8'h00);
      if (k < 64) exp_rx.push_back(resp(k));
    end
    hdr_q.delete();
    wr(3'd2, 16'(total));
    wr(3'd3, 16'(src));
    wr(3'd0, 16'h0013);
    for (int b = 0; b < total * 8; b++) begin
      lo = 0; while (!spi_sck) begin lo++; @(negedge clk); end
      hi = 0; while (spi_sck)  begin hi++; @(negedge clk); end
      if (b == 0) begin
        chk("R7 chip-select lead", lo, half);
        chk("R6 clock high phase", hi, half);
      end
      if (b == 1) chk("R6 clock low phase", lo, half);
    end
    tail = 0; while (!spi_cs_n) begin tail++; @(negedge clk); end
    chk("R7 chip-select tail", tail, half);
    rd(3'd0, v); chk("R5 start bit clear after burst", int'(v[4]), 0);
    rd(3'd6, v); chk("R4 receive level", int'(v[6:0]), (total > 64) ? 64 : total);
    if (drain) begin
      while (exp_rx.size() != 0) begin
        rd(3'd5, v); chk("R4 receive byte", int'(v), int'(exp_rx.pop_front()));
      end
    end else exp_rx.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int polls;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, v); chk("R1 control after reset", int'(v), 0);
    rd(3'd1, v); chk("R1 divider after reset", int'(v), 'h1000);
    rd(3'd6, v); chk("R1 status after reset", int'(v), 0);
    chk("R1 chip select idle", int'(spi_cs_n), 1);
    chk("R1 clock idle", int'(spi_sck), 0);

    // R5 start without enable/master is ignored
    wr(3'd2, 16'd2);
    wr(3'd0, 16'h0010);
    repeat (4) @(negedge clk);
    rd(3'd0, v); chk("R5 ignored start bit", int'(v[4]), 0);
    chk("R5 ignored start chip select", int'(spi_cs_n), 1);

    // R2 R3 R4: header then filler, divider 0x1000 (half 1)
    hdr_q = '{8'h03, 8'h12, 8'h34, 8'h56};
    run_burst(8, 4, 1, 1'b1);

    // R11 soft reset aborting a slow burst; R5 busy readback
    wr(3'd1, 16'h10FF);
    wr(3'd4, 16'h00EE);
    wr(3'd4, 16'h0099);
    wr(3'd2, 16'd4);
    wr(3'd3, 16'd1);
    wr(3'd0, 16'h0013);
    rd(3'd0, v); chk("R5 start bit reads 1 while running", int'(v[4]), 1);
    chk("R2 chip select low while running", int'(spi_cs_n), 0);
    exp_mosi.delete();
    wr(3'd0, 16'h0023);
    polls = 0;
    do begin rd(3'd0, v); polls++; end while (v[5] && polls < 50);
    chk("R11 soft reset bit self-clears", int'(v[5]), 0);
    chk("R11 control kept after soft reset", int'(v), 3);
    chk("R11 chip select released", int'(spi_cs_n), 1);
    rd(3'd6, v); chk("R11 status cleared", int'(v), 0);
    rd(3'd2, v); chk("R11 total count cleared", int'(v), 0);
    rd(3'd1, v); chk("R11 divider kept", int'(v), 'h10FF);

    // R6 ratio 4 via bit 12; R3 transmit FIFO runs dry before source count
    wr(3'd1, 16'h1001);
    hdr_q = '{8'hA1, 8'hB2};
    run_burst(5, 4, 2, 1'b1);

    // R6 power-of-two mode (bit 12 clear, M=2 -> half 4); R3 extra bytes stay queued
    wr(3'd1, 16'h0200);
    hdr_q = '{8'h5A, 8'h77};
    run_burst(3, 1, 4, 1'b1);
    rd(3'd6, v); chk("R3 unused byte left in transmit FIFO", int'(v[14:8]), 1);
    wr(3'd0, 16'h0007);
    rd(3'd6, v); chk("R8 transmit flush", int'(v[14:8]), 0);

    // R10 underflow, sticky, cleared by receive flush (R8)
    rd(3'd5, v); chk("R10 empty read returns zero", int'(v), 0);
    rd(3'd6, v); chk("R10 underflow flag set", int'(v[16]), 1);
    rd(3'd6, v); chk("R10 underflow flag sticky", int'(v[16]), 1);
    wr(3'd0, 16'h000B);
    rd(3'd6, v); chk("R8 receive flush clears underflow", int'(v[16]), 0);

    // R9 transmit overfill
    for (int i = 0; i < 66; i++) wr(3'd4, 16'(i));
    rd(3'd6, v); chk("R9 transmit level capped", int'(v[14:8]), 64);
    wr(3'd0, 16'h0007);

    // R4 full receive FIFO with all-filler burst, then R8 receive flush
    wr(3'd1, 16'h1000);
    run_burst(64, 0, 1, 1'b0);
    rd(3'd5, v); chk("R4 first byte of full FIFO", int'(v), int'(resp(0)));
    wr(3'd0, 16'h000B);
    rd(3'd6, v); chk("R8 receive flush", int'(v[6:0]), 0);

    chk("R3 all MOSI bytes seen", exp_mosi.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule